// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital serial front end of a two-channel DAC with 16-bit codes. A host sends 24-bit frames, MSB first, over a four-wire serial link: a 4-bit command in bits 23:20, a 4-bit channel address in bits 19:16 and a 16-bit payload in bits 15:0. The block holds one DAC register and one 2-bit power-down mode per channel and presents both on its outputs for the analog part of the chip. The serial pins are sampled by the system clock, which must run several times faster than the serial clock. Input data is captured on rising serial clock edges and output data changes on falling edges.

Frames are committed only when chip select rises after exactly 24 serial clock edges. A readback request returns the addressed DAC register on the serial output during the next frame. The output is driven only while that data is shifted out, unless the daisy-chain bit is set. When it is set, the output stays enabled and passes on the previously received frame. The serial output is a pad-level signal: `sdo_oe` low means the pin is high-impedance.

Top module: `dacif_top`

## Requirements
- R1: Command 4'b0011 loads the payload into channel A's DAC register when address bit 16 is set and into channel B's when address bit 19 is set (both when both are set). The new value is on `dac_a_val`/`dac_b_val` at the latest 2 clocks after chip select rises. After reset all registers and modes are zero and `sdo_oe` is low.
- R2: A frame with fewer or more than 24 serial clock edges changes no register, mode or flag.
- R3: Command 4'b0100 sets channel A's mode from bits 1:0 and channel B's from bits 7:6. The codes are 00 active, 01 1 kOhm to ground, 10 100 kOhm to ground and 11 three-state.
- R4: A power-down command leaves both DAC registers unchanged, and a DAC register write is accepted while its channel is powered down.
- R5: Command 4'b1001 changes no register and ignores its payload. During the next frame the serial output shifts out, MSB first, 4 zero bits, the 16-bit register and 4 zero bits.
- R6: A readback request reads channel B only when the address field is exactly 4'b1000. Every other address, including none or several bits set, reads channel A.
- R7: With daisy-chain off, `sdo_oe` is high only while chip select is low in the frame that follows a readback request, and low at all other times.
- R8: Command 4'b1000 sets the daisy-chain bit to payload bit 0 at the end of its frame. While the bit is set, `sdo_oe` stays high and, outside readback frames, the serial output shifts out the 24 bits of the frame received before.
- R9: Commands 4'b0000 and 4'b1111 change no register, mode or flag.
- R10: The readback data shifted out in a frame is the register value latched when the request frame ended, even if the frame carrying it writes that register or issues a new readback request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| dac_a_val | output | 16 | Channel A DAC register |
| dac_b_val | output | 16 | Channel B DAC register |
| pd_a | output | 2 | Channel A power-down mode |
| pd_b | output | 2 | Channel B power-down mode |

## Verification
Readback output and a register write can fall in the same frame. The frame that shifts out a channel's contents may itself write that channel or request another readback, so the commit at chip-select rise and the end of the readback happen on the same clock. The bench provokes this by following a readback of A with a write of A, and a readback of B with a readback of A. The scoreboard must see the pre-write value on the serial output, then the new value on the register port, and finally A's contents in the frame after.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int N_CH   = 2;
  localparam int CMD_W  = 4;
  localparam int ADR_W  = 4;
  localparam int PD_W   = 2;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP    = 4'h0,
    OP_WRITE  = 4'h3,
    OP_PWRDN  = 4'h4,
    OP_DCFG   = 4'h8,
    OP_RDBK   = 4'h9,
    OP_NOP_DC = 4'hF
  } op_e;

  typedef enum logic [PD_W-1:0] {
    PD_ACTIVE = 2'b00,
    PD_R1K    = 2'b01,
    PD_R100K  = 2'b10,
    PD_HIZ    = 2'b11
  } pdm_e;

  typedef struct packed {
    logic [N_CH-1:0] wr;
    logic            pd_set;
    logic            rb_req;
    logic            rb_sel_b;
    logic            dc_set;
  } dec_t;

endpackage

// File: rtl/dacif_frame_rx.sv
module dacif_frame_rx #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sclk_fall,
  output logic          cs_fall,
  output logic          cs_rise,
  output logic          frame_ok,
  output logic [FW-1:0] frame
);

  localparam int CNT_W   = $clog2(FW + 2);
  localparam int CNT_MAX = FW + 1;

  logic             sclk_q, cs_q;
  logic             sclk_rise;
  logic [CNT_W-1:0] bit_cnt, bit_cnt_n;
  logic [FW-1:0]    shreg_n;
  logic             shift_en;

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign cs_fall   = ~cs_n & cs_q;
  assign cs_rise   = cs_n & ~cs_q;
  assign shift_en  = ~cs_n & sclk_rise & ~cs_fall;
  assign frame_ok  = cs_rise & (bit_cnt == CNT_W'(FW));

  always_comb begin
    bit_cnt_n = bit_cnt;
    shreg_n   = frame;
    if (cs_fall) begin
      bit_cnt_n = '0;
    end else if (shift_en) begin
      shreg_n = {frame[FW-2:0], sdi};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt_n = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      frame   <= '0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      bit_cnt <= bit_cnt_n;
      if (shift_en) frame <= shreg_n;
    end
  end

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (bit_cnt == '0));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_W'(CNT_MAX)) |=> (bit_cnt == CNT_W'(CNT_MAX)) || (bit_cnt == '0));

endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
(
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [ADR_W-1:0] addr,
  output dec_t             dec
);

  localparam int ADR_STRIDE = ADR_W - 1;

  always_comb begin
    dec = '0;
    if (valid) begin
      unique case (op_e'(cmd))
        OP_WRITE: begin
          for (int c = 0; c < N_CH; c++) dec.wr[c] = addr[c*ADR_STRIDE];
        end
        OP_PWRDN: dec.pd_set = 1'b1;
        OP_RDBK:  begin
          dec.rb_req   = 1'b1;
          dec.rb_sel_b = (addr == 4'b1000);
        end
        OP_DCFG:  dec.dc_set = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            pd_en,
  input  logic [PD_W-1:0] pd_code,
  output logic [DW-1:0]   dac_q,
  output logic [PD_W-1:0] pd_q
);

  logic [DW-1:0]   dac_n;
  logic [PD_W-1:0] pd_n;

  always_comb begin
    dac_n = dac_q;
    pd_n  = pd_q;
    if (wr_en) dac_n = wr_data;
    if (pd_en) pd_n  = pd_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      pd_q  <= PD_ACTIVE;
    end else begin
      if (wr_en) dac_q <= dac_n;
      if (pd_en) pd_q  <= pd_n;
    end
  end

  // R4
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en && !wr_en) |=> $stable(dac_q));

endmodule

// File: rtl/dacif_sdo.sv
module dacif_sdo #(
  parameter int FW = 24,
  parameter int DW = 16,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sclk_fall,
  input  logic          rb_load,
  input  logic [DW-1:0] rb_val,
  input  logic          dc_load,
  input  logic          dc_val,
  input  logic          chain_msb,
  output logic          sdo,
  output logic          sdo_oe
);

  localparam int TW = FW - HW - DW;

  logic [FW-1:0] out_sr, out_sr_n;
  logic          rb_pend, rb_pend_n;
  logic          rb_act, rb_act_n;
  logic          dc_en, dc_en_n;

  always_comb begin
    out_sr_n  = out_sr;
    rb_pend_n = rb_pend;
    rb_act_n  = rb_act;
    dc_en_n   = dc_en;
    if (cs_fall && rb_pend) begin
      rb_act_n  = 1'b1;
      rb_pend_n = 1'b0;
    end
    if (cs_rise) rb_act_n = 1'b0;
    if (rb_act && !cs_n && sclk_fall) out_sr_n = {out_sr[FW-2:0], 1'b0};
    if (rb_load) begin
      out_sr_n  = {{HW{1'b0}}, rb_val, {TW{1'b0}}};
      rb_pend_n = 1'b1;
    end
    if (dc_load) dc_en_n = dc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr  <= '0;
      rb_pend <= 1'b0;
      rb_act  <= 1'b0;
      dc_en   <= 1'b0;
    end else begin
      out_sr  <= out_sr_n;
      rb_pend <= rb_pend_n;
      rb_act  <= rb_act_n;
      dc_en   <= dc_en_n;
    end
  end

  assign sdo_oe = rb_act | dc_en;
  assign sdo    = rb_act ? out_sr[FW-1] : chain_msb;

  // R7
  rb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !rb_act);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && !dc_en) |-> !sdo_oe);

  // R5
  rb_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_act) |-> ($past(rb_pend) && !cs_n));

endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [DW-1:0] dac_a_val,
  output logic [DW-1:0] dac_b_val,
  output logic [1:0]    pd_a,
  output logic [1:0]    pd_b
);

  localparam int FW        = CMD_W + ADR_W + DW;
  localparam int PD_STRIDE = 6;

  logic          rst_m, rst_s;
  logic          sclk_fall, cs_fall, cs_rise, frame_ok;
  logic [FW-1:0] frame;
  dec_t          dec;
  logic [DW-1:0] dac_vals [N_CH];
  logic [PD_W-1:0] pd_vals [N_CH];
  logic [DW-1:0] rb_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  dacif_frame_rx #(.FW(FW)) u_rx (
    .clk(clk), .rst_n(rst_s), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .frame_ok(frame_ok), .frame(frame)
  );

  dacif_decode u_dec (
    .valid(frame_ok),
    .cmd(frame[FW-1 -: CMD_W]),
    .addr(frame[DW +: ADR_W]),
    .dec(dec)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dacif_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_s),
      .wr_en(dec.wr[c]), .wr_data(frame[DW-1:0]),
      .pd_en(dec.pd_set), .pd_code(frame[c*PD_STRIDE +: PD_W]),
      .dac_q(dac_vals[c]), .pd_q(pd_vals[c])
    );
  end

  assign rb_val = dec.rb_sel_b ? dac_vals[1] : dac_vals[0];

  dacif_sdo #(.FW(FW), .DW(DW), .HW(CMD_W)) u_sdo (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .rb_load(dec.rb_req), .rb_val(rb_val),
    .dc_load(dec.dc_set), .dc_val(frame[0]), .chain_msb(frame[FW-1]),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign dac_a_val = dac_vals[0];
  assign dac_b_val = dac_vals[1];
  assign pd_a      = pd_vals[0];
  assign pd_b      = pd_vals[1];

  // R1
  hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !frame_ok |=> ($stable(dac_a_val) && $stable(dac_b_val) && $stable(pd_a) && $stable(pd_b)));

endmodule

// File: tb/sim_dacif_top.sv
module sim_dacif_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic [15:0] dac_a_val, dac_b_val;
  logic [1:0]  pd_a, pd_b;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] ea = '0, eb = '0;
  logic [1:0]  epa = '0, epb = '0;
  logic        edc = 1'b0;

  typedef struct {
    bit          chk_sdo;
    logic [23:0] exp_word;
    logic        exp_oe;
    string       req;
  } item_t;

  item_t       sb_q[$];
  logic [23:0] rx_word;
  logic        oe_all, oe_any;
  event        frame_done;

  always #10 clk = ~clk;

  dacif_top u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .dac_a_val(dac_a_val), .dac_b_val(dac_b_val),
    .pd_a(pd_a), .pd_b(pd_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {16'h0, dac_a_val}, {16'h0, ea});
    check(req, {16'h0, dac_b_val}, {16'h0, eb});
    check(req, {28'h0, pd_b, pd_a}, {28'h0, epb, epa});
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, input bit chk,
                      input logic [23:0] exp_word, input logic exp_oe, input string req);
    item_t it;
    it.chk_sdo = chk; it.exp_word = exp_word; it.exp_oe = exp_oe; it.req = req;
    sb_q.push_back(it);
    rx_word = '0; oe_all = 1'b1; oe_any = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b1;
      repeat (2) @(negedge clk);
      if (i < 24) rx_word[23-i] = sdo;
      oe_all &= sdo_oe;
      oe_any |= sdo_oe;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    -> frame_done;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      @(frame_done);
      if (sb_q.size() == 0) begin
        check("scoreboard", 32'h1, 32'h0);
      end else begin
        it = sb_q.pop_front();
        check({it.req, " oe"}, {30'h0, oe_any, oe_all}, {30'h0, it.exp_oe, it.exp_oe});
        if (it.chk_sdo) check({it.req, " sdo"}, {8'h0, rx_word}, {8'h0, it.exp_word});
      end
    end
  end

  task automatic wr(input logic [3:0] addr, input logic [15:0] d);
    xfer({4'b0011, addr, d}, 24, 1'b0, '0, edc, "R1 write");
    if (addr[0]) ea = d;
    if (addr[3]) eb = d;
  endtask

  task automatic pdn(input logic [1:0] b, input logic [1:0] a);
    xfer({4'b0100, 4'b0000, 8'h00, b, 4'b1111, a}, 24, 1'b0, '0, edc, "R3 pd");
    epa = a; epb = b;
  endtask

  // readback request then a follow-up frame carrying the data
  task automatic rdbk(input logic [3:0] addr, input logic [15:0] expv, input string req);
    xfer({4'b1001, addr, 16'hFFFF}, 24, 1'b0, '0, edc, req);
    check({req, " R5 no change"}, {16'h0, dac_a_val}, {16'h0, ea});
    xfer(edc ? 24'hF00000 : 24'h000000, 24, 1'b1, {4'h0, expv, 4'h0}, 1'b1, req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 reset");
    check("R7 reset oe", {31'h0, sdo_oe}, 32'h0);

    // R1 writes
    wr(4'b0001, 16'h1234); check_state("R1 write A");
    wr(4'b1000, 16'hBEEF); check_state("R1 write B");
    wr(4'b1001, 16'h5A5A); check_state("R1 write both");

    // R2 wrong-length frames
    xfer({4'b0011, 4'b0001, 16'hFFFF}, 23, 1'b0, '0, 1'b0, "R2 short");
    check_state("R2 short frame");
    xfer({4'b0011, 4'b1001, 16'hFFFF}, 25, 1'b0, '0, 1'b0, "R2 long");
    check_state("R2 long frame");
    wr(4'b0001, 16'h0042); check_state("R2 good after bad");

    // R3 / R4 power-down
    pdn(2'b10, 2'b01); check_state("R3 pd 1k/100k");
    pdn(2'b11, 2'b11); check_state("R3 pd tristate");
    wr(4'b0001, 16'h0F0F); check_state("R4 write while down");
    pdn(2'b00, 2'b00); check_state("R4 power up keeps code");

    // R5 / R6 / R7 readback
    rdbk(4'b0001, ea, "R5 rb A");
    check("R7 idle oe", {31'h0, sdo_oe}, 32'h0);
    rdbk(4'b1000, eb, "R6 rb B");
    rdbk(4'b0000, ea, "R6 rb none");
    rdbk(4'b1001, ea, "R6 rb both");
    rdbk(4'b0100, ea, "R6 rb dontcare bit");

    // R10 readback frame overlapping a write of the same channel
    xfer(24'h910000, 24, 1'b0, '0, 1'b0, "R10 req A");
    xfer({4'b0011, 4'b0001, 16'h7777}, 24, 1'b1, {4'h0, ea, 4'h0}, 1'b1, "R10 old value");
    ea = 16'h7777;
    check_state("R10 write landed");
    // R10 readback frame carrying a new request
    xfer(24'h980000, 24, 1'b0, '0, 1'b0, "R10 req B");
    xfer(24'h910000, 24, 1'b1, {4'h0, eb, 4'h0}, 1'b1, "R10 B out");
    xfer(24'h000000, 24, 1'b1, {4'h0, ea, 4'h0}, 1'b1, "R10 A out");

    // R9 no-ops
    xfer(24'h000000, 24, 1'b0, '0, 1'b0, "R9 nop0");
    xfer(24'hF9ABCD, 24, 1'b0, '0, 1'b0, "R9 nopF");
    check_state("R9 nop state");
    check("R9 idle oe", {31'h0, sdo_oe}, 32'h0);

    // R8 daisy chain
    xfer(24'h800001, 24, 1'b0, '0, 1'b0, "R8 enable");
    edc = 1'b1;
    check("R8 idle oe", {31'h0, sdo_oe}, 32'h1);
    xfer(24'hF12345, 24, 1'b1, 24'h800001, 1'b1, "R8 pass cfg");
    xfer(24'hF00000, 24, 1'b1, 24'hF12345, 1'b1, "R8 pass prev");
    xfer(24'h910000, 24, 1'b1, 24'hF00000, 1'b1, "R8 pass before rb");
    xfer(24'hF00000, 24, 1'b1, {4'h0, ea, 4'h0}, 1'b1, "R8 rb in chain");
    xfer(24'h800000, 24, 1'b1, 24'hF00000, 1'b1, "R8 disable");
    edc = 1'b0;
    check("R8 off oe", {31'h0, sdo_oe}, 32'h0);
    check_state("R8 state");

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule